// File: doc/BRIEF.md
# Dual-Output Power-of-Two Clock Divider with Clean Stop

This block takes a fast input clock and divides it by a selectable power of two to make output A. Output B follows A at the same rate or at half of it. Both outputs are produced directly from registers, so neither one glitches. Every ratio gives a 50% duty cycle.

Each output has its own active-low stop input. The stop and restart decisions are taken only at the point where that output would fall. As a result, the output never shows a shortened high phase. Changes to the ratio selects wait for a common low boundary of both outputs. The block sits after a frequency synthesizer's oscillator and feeds the output drivers.

Top module: `clk_postdiv`

## Requirements
- R1: While `rst_n` is low, both outputs are low. At the first rising clock edge after release, every output whose stop input is high goes high and starts a full period.
- R2: For `sel_a` codes 0, 1, 2, 3, 4 and 5, output A has a period of 2, 4, 8, 16, 32 and 64 input cycles. It is high for the first half of each period.
- R3: `sel_a` codes 6 and 7 give the same 64-cycle period as code 5.
- R4: With `b_half` = 0 and both outputs running, output B is identical to output A, cycle for cycle.
- R5: With `b_half` = 1, output B has twice the period of A, a 50% duty cycle, and rises together with every other rising edge of A.
- R6: A stop input that is low at the clock edge where its output would fall holds that output low from then on. A high phase that is already under way always completes.
- R7: A stopped output resumes only after a would-be falling point at which its stop input is high. It then restarts at the start of its next period.
- R8: `sel_a` and `b_half` are sampled only at the edge that begins a new span of two A periods, and at the first edge after reset. Any other change has no effect until that edge.
- R9: The stop inputs are independent. Stopping one output does not change the timing of the other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| sel_a | input | 3 | A ratio code (0..5 -> /2../64, 6 and 7 -> /64) |
| b_half | input | 1 | 0: B at the A rate, 1: B at half the A rate |
| stop_a_n | input | 1 | Active-low stop for output A |
| stop_b_n | input | 1 | Active-low stop for output B |
| out_a | output | 1 | Divided clock A |
| out_b | output | 1 | Divided clock B |

## Verification
Every output is one register past its inputs. A level applied at a rising edge therefore shows up on the outputs in that same edge's result and can be sampled at the following falling edge.

Stop, restart and select changes are different. Their effect depends on where the edge falls in the span, so the delay can be anything from one edge up to a full span of two A periods.

The bench model advances once per rising edge. It applies select changes only at span starts and stop changes only at would-be falling points. Both outputs are compared against the model at every falling edge, so the variable latency is checked exactly rather than through a fixed delay.

// File: rtl/clk_postdiv.sv
module clk_postdiv #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_a,
  input  logic             b_half,
  input  logic             stop_a_n,
  input  logic             stop_b_n,
  output logic             out_a,
  output logic             out_b
);
  localparam int CW = MAX_LOG + 1;
  localparam int KW = $clog2(MAX_LOG);

  logic          live;
  logic [CW-1:0] cnt, cnt_nx, last;
  logic [KW-1:0] k_q, k_nx, sel_k;
  logic          half_q, half_nx;
  logic          run_a, run_b, run_a_nx, run_b_nx;
  logic          a_now, b_now, a_nx, b_nx;
  logic          wrap, load;

  assign sel_k = (int'(sel_a) >= MAX_LOG) ? KW'(MAX_LOG - 1) : KW'(sel_a);

  // span of two A periods: 2^(k+2) input cycles
  assign last    = CW'((32'd1 << (int'(k_q) + 2)) - 32'd1);
  assign wrap    = live && (cnt == last);
  assign load    = !live || wrap;
  assign cnt_nx  = load ? '0 : cnt + CW'(1);
  assign k_nx    = load ? sel_k  : k_q;
  assign half_nx = load ? b_half : half_q;

  assign a_now = !cnt[int'(k_q)];
  assign b_now = half_q  ? !cnt[int'(k_q) + 1]    : a_now;
  assign a_nx  = !cnt_nx[int'(k_nx)];
  assign b_nx  = half_nx ? !cnt_nx[int'(k_nx) + 1] : a_nx;

  assign run_a_nx = (!live || (a_now && !a_nx)) ? stop_a_n : run_a;
  assign run_b_nx = (!live || (b_now && !b_nx)) ? stop_b_n : run_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      cnt    <= '0;
      k_q    <= '0;
      half_q <= 1'b0;
      run_a  <= 1'b0;
      run_b  <= 1'b0;
      out_a  <= 1'b0;
      out_b  <= 1'b0;
    end else begin
      live   <= 1'b1;
      cnt    <= cnt_nx;
      k_q    <= k_nx;
      half_q <= half_nx;
      run_a  <= run_a_nx;
      run_b  <= run_b_nx;
      out_a  <= run_a_nx & a_nx;
      out_b  <= run_b_nx & b_nx;
    end
  end
endmodule

// File: rtl/clk_postdiv_chk.sv
module clk_postdiv_chk #(
  parameter int CW = 7,
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_a,
  input logic          out_b,
  input logic          live,
  input logic          run_a,
  input logic          run_b,
  input logic          half_q,
  input logic [CW-1:0] cnt,
  input logic [KW-1:0] k_q
);
  a_r1_reset_low: assert property (@(negedge clk) !rst_n |-> (!out_a && !out_b));

  a_r4_b_tracks_a: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !half_q && run_a && run_b) |-> (out_a == out_b));

  a_r5_b_rise_with_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_b) && run_a) |-> $rose(out_a));

  a_r6_stop_when_low_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(live) && !$stable(run_a)) |-> !out_a);

  a_r6_stop_when_low_b: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(live) && !$stable(run_b)) |-> !out_b);

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cnt != '0) |-> ($stable(k_q) && $stable(half_q)));
endmodule

bind clk_postdiv clk_postdiv_chk #(.CW(CW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_a(out_a), .out_b(out_b), .live(live),
  .run_a(run_a), .run_b(run_b), .half_q(half_q), .cnt(cnt), .k_q(k_q)
);

// File: tb/test_clk_postdiv.sv
module test_clk_postdiv;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel_a = 3'd0;
  logic b_half = 1'b0, stop_a_n = 1'b1, stop_b_n = 1'b1;
  logic out_a, out_b;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit armed = 0, started = 0;
  int pos = 0, lg = 0;
  bit hf = 0, ra = 0, rb = 0, ea = 0, eb = 0;

  clk_postdiv i_clk_postdiv (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .b_half(b_half),
    .stop_a_n(stop_a_n), .stop_b_n(stop_b_n), .out_a(out_a), .out_b(out_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratio_log(input logic [2:0] s);
    return (s > 3'd5) ? 5 : int'(s);
  endfunction
  function automatic bit lvl_a(input int p, input int l);
    int r = 2 << l;
    return (p % r) < (r / 2);
  endfunction
  function automatic bit lvl_b(input int p, input int l, input bit h);
    int r = h ? (4 << l) : (2 << l);
    return (p % r) < (r / 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      started = 0; ra = 0; rb = 0; ea = 0; eb = 0;
    end else begin
      if (!started) begin
        started = 1; pos = 0; lg = ratio_log(sel_a); hf = b_half;
        ra = stop_a_n; rb = stop_b_n;
      end else begin
        bit oa, ob;
        oa = lvl_a(pos, lg);
        ob = lvl_b(pos, lg, hf);
        pos = pos + 1;
        if (pos == (4 << lg)) begin
          pos = 0; lg = ratio_log(sel_a); hf = b_half;
        end
        if (oa && !lvl_a(pos, lg)) ra = stop_a_n;
        if (ob && !lvl_b(pos, lg, hf)) rb = stop_b_n;
      end
      ea = ra && lvl_a(pos, lg);
      eb = rb && lvl_b(pos, lg, hf);
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (out_a !== ea) begin
        failures++;
        $display("FAIL %s out_a actual=%b expected=%b at %0t", cur_req, out_a, ea, $time);
      end
      checks++;
      if (out_b !== eb) begin
        failures++;
        $display("FAIL %s out_b actual=%b expected=%b at %0t", cur_req, out_b, eb, $time);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    run(5);
    cur_req = "R2"; rst_n = 1'b1;
    run(40);
    for (int s = 1; s <= 5; s++) begin
      sel_a = 3'(s);
      run(300);
    end
    cur_req = "R3"; sel_a = 3'd6; run(300);
    sel_a = 3'd7; run(300);
    cur_req = "R5"; sel_a = 3'd2; b_half = 1'b1; run(200);
    cur_req = "R4"; b_half = 1'b0; run(200);
    cur_req = "R6"; sel_a = 3'd3; run(37); stop_a_n = 1'b0; run(150);
    cur_req = "R7"; run(13); stop_a_n = 1'b1; run(150);
    cur_req = "R9"; b_half = 1'b1; run(21); stop_b_n = 1'b0; run(200);
    stop_b_n = 1'b1; run(120);
    cur_req = "R8"; run(5); sel_a = 3'd0; run(3); sel_a = 3'd4; run(11);
    b_half = 1'b0; run(7); sel_a = 3'd1; run(200);
    cur_req = "R6"; sel_a = 3'd0; run(50);
    stop_a_n = 1'b0; stop_b_n = 1'b0; run(30);
    cur_req = "R7"; stop_a_n = 1'b1; stop_b_n = 1'b1; run(30);
    cur_req = "R1"; rst_n = 1'b0; run(6);
    sel_a = 3'd2; stop_b_n = 1'b0; rst_n = 1'b1; run(60);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule